// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block picks, from a parameterized set of interrupt sources (32 by default, vector numbers 0 to N-1), the single request that is offered to the processor. Each source has its own 4-bit priority level held in a small register file. A source takes part in arbitration when its pending bit and its enable bit are both set and its level is strictly above the processor's current 4-bit interrupt priority level. The highest level wins. On equal levels the lower vector number wins. Level 0 takes the source out of normal arbitration.

One source can be promoted to a fast interrupt through a dedicated configuration register. When that source is pending and enabled, it wins against every normal request, whatever its own level or the processor level. A separate transfer-request vector forwards every enabled pending source unchanged, with no regard to the priority settings. The winner, its level, a valid flag and a fast flag are all registered.

A byte-wide register port reaches the priority registers and the fast configuration register. If software writes a priority while that source is enabled, a sticky error flag is raised, and the write still takes effect.

Top module: `irq_prio_arb`

## Requirements
- R1: After synchronous reset, every priority register and the fast register read 0, and `irq_valid`, `irq_vec`, `irq_lvl`, `irq_fast`, `xfer_req` and `cfg_err` are all 0.
- R2: A source whose priority level is 0 never wins as a normal request. When no request qualifies, `irq_valid` is 0 and `irq_vec` and `irq_lvl` read 0.
- R3: A normal request qualifies only if it is pending, enabled and its level is strictly greater than `cpu_lvl`.
- R4: Among qualifying requests, the one with the numerically highest level wins. `irq_lvl` reports that level.
- R5: Among qualifying requests at the same highest level, the lowest vector number wins.
- R6: The fast register is at address N. Bit 7 enables it and the low log2(N) bits select the vector. While it is enabled and the selected source is pending and enabled, that source wins. `irq_fast` is 1 and `irq_lvl` shows its register level, even at level 0 or with `cpu_lvl` = 15.
- R7: Address a < N selects the priority register of source a. Level sits in bits 3:0. Bits 7:4 ignore writes and read 0. Unused addresses read 0. `reg_rdata` is registered: it shows the data for the address presented at the previous clock edge.
- R8: `xfer_req` equals `pend & en`, delayed by one clock, whatever the priority and fast settings.
- R9: A write to a priority register while that source's enable bit is 1 sets `cfg_err`. The flag stays set until reset. The write still takes effect.
- R10: `irq_valid`, `irq_vec`, `irq_lvl` and `irq_fast` change exactly one clock edge after the change in `pend`, `en` or `cpu_lvl` that causes them, and stay unchanged before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend | input | N | Pending bit per source |
| en | input | N | Enable bit per source |
| cpu_lvl | input | 4 | Current processor interrupt priority level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | clog2(N+1) | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_valid | output | 1 | A request is offered to the processor |
| irq_vec | output | clog2(N) | Winning vector number |
| irq_lvl | output | 4 | Priority level of the winner |
| irq_fast | output | 1 | Winner is the fast source |
| xfer_req | output | N | Enabled pending sources, unfiltered |
| cfg_err | output | 1 | Sticky flag: priority written while enabled |

## Verification
Exact ties at the top level, spread across vectors far apart, are the hardest case to produce from random stimulus, because the tie-break is only visible when the lower-numbered tie sits in a different branch of the comparison tree than the upper one. Directed cases put equal levels at vectors 7 and 20 and give every source the same level. Random rounds draw levels from a narrow range so that ties happen often. A reference scan from vector 0 upward checks each round, including rounds where every pending level is 0 or at or below `cpu_lvl`.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  localparam int REG_W = 8;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VEC_W  = $clog2(N),
  parameter int ADDR_W = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  reg_t               reg_wdata,
  input  logic [N-1:0]       en,
  output logic [N*LVL_W-1:0] prio_flat,
  output logic               fast_en,
  output logic [VEC_W-1:0]   fast_vec,
  output reg_t               reg_rdata,
  output logic               cfg_err
);
  localparam logic [ADDR_W-1:0] FAST_ADDR = ADDR_W'(N);

  lvl_t prio_q [N];
  logic hit_prio;
  logic [VEC_W-1:0] idx;
  reg_t fast_byte;

  assign idx      = reg_addr[VEC_W-1:0];
  assign hit_prio = reg_addr < FAST_ADDR;

  for (genvar i = 0; i < N; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst) prio_q[i] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(i)) prio_q[i] <= reg_wdata[LVL_W-1:0];
    end
    assign prio_flat[i*LVL_W +: LVL_W] = prio_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_en  <= 1'b0;
      fast_vec <= '0;
    end else if (reg_wr && reg_addr == FAST_ADDR) begin
      fast_en  <= reg_wdata[REG_W-1];
      fast_vec <= reg_wdata[VEC_W-1:0];
    end
  end

  always_comb begin
    fast_byte = '0;
    fast_byte[REG_W-1] = fast_en;
    fast_byte[VEC_W-1:0] = fast_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (hit_prio) reg_rdata <= {{(REG_W-LVL_W){1'b0}}, prio_q[idx]};
    else if (reg_addr == FAST_ADDR) reg_rdata <= fast_byte;
    else reg_rdata <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else if (reg_wr && hit_prio && en[idx]) cfg_err <= 1'b1;
  end
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
  import irq_arb_pkg::*;
#(
  parameter int N     = 32,
  parameter int VEC_W = $clog2(N)
) (
  input  logic [N-1:0]       req,
  input  logic [N*LVL_W-1:0] prio_flat,
  output logic               win_valid,
  output logic [VEC_W-1:0]   win_vec,
  output lvl_t               win_lvl
);
  localparam int P     = 1 << VEC_W;
  localparam int NODES = 2 * P - 1;

  logic             nv [NODES];
  lvl_t             nl [NODES];
  logic [VEC_W-1:0] nx [NODES];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign nv[P-1+i] = req[i];
      assign nl[P-1+i] = prio_flat[i*LVL_W +: LVL_W];
      assign nx[P-1+i] = VEC_W'(i);
    end else begin : g_pad
      assign nv[P-1+i] = 1'b0;
      assign nl[P-1+i] = '0;
      assign nx[P-1+i] = '0;
    end
  end

  // left child always covers lower vectors; it keeps ties
  for (genvar k = 0; k < P - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || (nl[2*k+2] > nl[2*k+1]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign nl[k]  = take_r ? nl[2*k+2] : nl[2*k+1];
    assign nx[k]  = take_r ? nx[2*k+2] : nx[2*k+1];
  end

  assign win_valid = nv[0];
  assign win_vec   = nv[0] ? nx[0] : '0;
  assign win_lvl   = nv[0] ? nl[0] : '0;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int N      = 32,
  parameter int VEC_W  = $clog2(N),
  parameter int ADDR_W = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      pend,
  input  logic [N-1:0]      en,
  input  logic [3:0]        cpu_lvl,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [3:0]        irq_lvl,
  output logic              irq_fast,
  output logic [N-1:0]      xfer_req,
  output logic              cfg_err
);
  localparam bit FULL = (N == (1 << VEC_W));

  logic [N*LVL_W-1:0] prio_flat;
  logic               fast_en;
  logic [VEC_W-1:0]   fast_vec;
  logic [N-1:0]       live;
  logic [N-1:0]       norm_req;
  logic               win_valid;
  logic [VEC_W-1:0]   win_vec;
  lvl_t               win_lvl;
  logic               fvec_ok;
  logic               fast_hit;
  lvl_t               fast_lvl;

  irq_prio_regs #(.N(N), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en(en), .prio_flat(prio_flat),
    .fast_en(fast_en), .fast_vec(fast_vec), .reg_rdata(reg_rdata),
    .cfg_err(cfg_err)
  );

  assign live = pend & en;

  for (genvar i = 0; i < N; i++) begin : g_elig
    lvl_t p;
    assign p = prio_flat[i*LVL_W +: LVL_W];
    assign norm_req[i] = live[i] && (p != '0) && (p > cpu_lvl);
  end

  irq_arb_tree #(.N(N), .VEC_W(VEC_W)) u_tree (
    .req(norm_req), .prio_flat(prio_flat),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  if (FULL) begin : g_fv_full
    assign fvec_ok = 1'b1;
  end else begin : g_fv_part
    assign fvec_ok = int'(fast_vec) < N;
  end

  assign fast_hit = fast_en && fvec_ok && live[fast_vec];
  assign fast_lvl = fvec_ok ? prio_flat[fast_vec*LVL_W +: LVL_W] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      irq_fast  <= 1'b0;
      xfer_req  <= '0;
    end else begin
      xfer_req <= live;
      if (fast_hit) begin
        irq_valid <= 1'b1;
        irq_vec   <= fast_vec;
        irq_lvl   <= fast_lvl;
        irq_fast  <= 1'b1;
      end else begin
        irq_valid <= win_valid;
        irq_vec   <= win_vec;
        irq_lvl   <= win_lvl;
        irq_fast  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
  parameter int N      = 32,
  parameter int VEC_W  = $clog2(N),
  parameter int ADDR_W = $clog2(N + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      en,
  input logic [3:0]        cpu_lvl,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vec,
  input logic [3:0]        irq_lvl,
  input logic              irq_fast,
  input logic [N-1:0]      xfer_req,
  input logic              cfg_err
);
  logic [N-1:0] live_q;
  always_ff @(posedge clk) live_q <= pend & en;

  AST_NORM_ABOVE_CPU: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_fast) |-> (irq_lvl > $past(cpu_lvl))); // R3
  AST_NORM_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_fast) |-> (irq_lvl != 4'd0)); // R2
  AST_WIN_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> live_q[irq_vec]); // R4
  AST_FAST_IMPLIES_VALID: assert property (@(posedge clk) disable iff (rst)
    irq_fast |-> irq_valid); // R6
  AST_XFER_UNFILTERED: assert property (@(posedge clk) disable iff (rst)
    xfer_req == live_q); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err); // R9
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) < ADDR_W'(N)) |-> (reg_rdata[7:4] == 4'd0)); // R7
endmodule

bind irq_prio_arb irq_arb_chk #(.N(N), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_prio_arb_tb.sv
`timescale 1ns/1ps
module irq_prio_arb_tb;
  localparam int N = 32;
  localparam int VEC_W = $clog2(N);
  localparam int ADDR_W = $clog2(N + 1);

  logic clk = 0, rst = 1;
  logic [N-1:0] pend = '0, en = '0;
  logic [3:0] cpu_lvl = '0;
  logic reg_wr = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_valid, irq_fast, cfg_err;
  logic [VEC_W-1:0] irq_vec;
  logic [3:0] irq_lvl;
  logic [N-1:0] xfer_req;

  int checks = 0, fails = 0;
  logic [3:0] mp [N];
  logic m_fen = 0;
  logic [VEC_W-1:0] m_fvec = '0;

  always #4 clk = ~clk;

  irq_prio_arb #(.N(N)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    @(negedge clk);
    reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    if (a < N) mp[a] = d[3:0];
    else if (a == N) begin m_fen = d[7]; m_fvec = d[VEC_W-1:0]; end
  endtask

  task automatic rd_chk(string req, int a, logic [7:0] exp);
    @(negedge clk);
    reg_addr = ADDR_W'(a);
    @(negedge clk);
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  // reference: scan from vector 0 upward, strict compare keeps lower vector
  task automatic expect_arb(string req);
    logic ev = 0, ef = 0;
    logic [VEC_W-1:0] evec = '0;
    logic [3:0] elvl = '0;
    for (int v = 0; v < N; v++) begin
      if (pend[v] && en[v]) begin
        if (m_fen && v == int'(m_fvec)) begin
          ef = 1; ev = 1; evec = VEC_W'(v); elvl = mp[v];
          break;
        end
        if (mp[v] > cpu_lvl && (!ev || mp[v] > elvl)) begin
          ev = 1; evec = VEC_W'(v); elvl = mp[v];
        end
      end
    end
    @(negedge clk);
    chk({req, " valid"}, 32'(irq_valid), 32'(ev));
    chk({req, " vec"}, 32'(irq_vec), 32'(evec));
    chk({req, " lvl"}, 32'(irq_lvl), 32'(elvl));
    chk({req, " fast"}, 32'(irq_fast), 32'(ef));
  endtask

  task automatic quiet();
    @(negedge clk);
    pend = '0; en = '0; cpu_lvl = '0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) mp[i] = '0;
    chk("R1 valid", 32'(irq_valid), 0);
    chk("R1 vec", 32'(irq_vec), 0);
    chk("R1 lvl", 32'(irq_lvl), 0);
    chk("R1 fast", 32'(irq_fast), 0);
    chk("R1 xfer", 32'(xfer_req), 0);
    chk("R1 err", 32'(cfg_err), 0);
    rd_chk("R1 prio", 5, 8'h00);
    rd_chk("R1 fastreg", N, 8'h00);
  endtask

  task automatic t_regmap();
    quiet();
    wr_reg(5, 8'hF7);
    rd_chk("R7 reserved bits", 5, 8'h07);
    wr_reg(N, 8'hFF);
    rd_chk("R7 fast reg", N, 8'h80 | 8'(N - 1));
    wr_reg(N, 8'h00);
    rd_chk("R7 unused", N + 1, 8'h00);
    wr_reg(5, 8'h00);
  endtask

  task automatic t_level0();
    quiet();
    for (int i = 0; i < N; i++) wr_reg(i, 8'h00);
    @(negedge clk);
    pend = '1; en = '1; cpu_lvl = 0;
    expect_arb("R2 all level 0");
    chk("R8 xfer all", 32'(xfer_req), 32'hFFFF_FFFF);
  endtask

  task automatic t_cpu();
    quiet();
    for (int i = 0; i < N; i++) wr_reg(i, 8'h05);
    @(negedge clk);
    pend = '1; en = '1; cpu_lvl = 5;
    expect_arb("R3 level equal to cpu");
    cpu_lvl = 4;
    expect_arb("R5 all same level");
    chk("R5 vec zero", 32'(irq_vec), 0);
  endtask

  task automatic t_highest();
    quiet();
    for (int i = 0; i < N; i++) wr_reg(i, 8'h01);
    wr_reg(20, 8'h09); wr_reg(7, 8'h09); wr_reg(3, 8'h04); wr_reg(31, 8'h08);
    @(negedge clk);
    pend = '0; pend[20] = 1; pend[7] = 1; pend[3] = 1; pend[31] = 1;
    en = '1; cpu_lvl = 2;
    expect_arb("R4 highest level");
    chk("R5 tie 7 vs 20", 32'(irq_vec), 7);
    en[7] = 0;
    expect_arb("R4 tie removed");
    chk("R4 vec 20", 32'(irq_vec), 20);
  endtask

  task automatic t_fast();
    quiet();
    wr_reg(10, 8'h00); wr_reg(2, 8'h0F);
    wr_reg(N, 8'h80 | 8'd10);
    @(negedge clk);
    pend = '0; pend[10] = 1; pend[2] = 1; en = '1; cpu_lvl = 15;
    expect_arb("R6 fast at level 0");
    chk("R6 fast vec", 32'(irq_vec), 10);
    en[10] = 0;
    expect_arb("R6 fast disabled source");
    chk("R6 not fast", 32'(irq_fast), 0);
    cpu_lvl = 3;
    expect_arb("R6 normal after fast off");
    wr_reg(N, 8'h00);
  endtask

  task automatic t_latency();
    quiet();
    wr_reg(9, 8'h06);
    @(negedge clk);
    en = '1; pend = '0; pend[9] = 1; cpu_lvl = 0;
    #1 chk("R10 before edge", 32'(irq_valid), 0);
    @(negedge clk);
    chk("R10 after edge", 32'(irq_valid), 1);
    chk("R10 vec", 32'(irq_vec), 9);
    cpu_lvl = 6;
    #1 chk("R10 hold", 32'(irq_valid), 1);
    @(negedge clk);
    chk("R10 drop", 32'(irq_valid), 0);
  endtask

  task automatic t_random();
    for (int r = 0; r < 12; r++) begin
      quiet();
      for (int i = 0; i < N; i++) wr_reg(i, 8'($urandom_range(0, (r % 3 == 0) ? 15 : 3)));
      if (r % 4 == 3) wr_reg(N, 8'h80 | 8'($urandom_range(0, N - 1)));
      else wr_reg(N, 8'h00);
      for (int k = 0; k < 40; k++) begin
        pend = N'($urandom); en = N'($urandom);
        if (k % 5 == 0) en = '1;
        cpu_lvl = 4'($urandom_range(0, 15));
        if (k % 7 == 0) cpu_lvl = 0;
        expect_arb("R4 R5 R6 random");
        chk("R8 random xfer", 32'(xfer_req), 32'(pend & en));
      end
    end
    wr_reg(N, 8'h00);
  endtask

  task automatic t_err();
    quiet();
    wr_reg(4, 8'h02);
    chk("R9 no error when disabled", 32'(cfg_err), 0);
    @(negedge clk);
    en = '0; en[3] = 1;
    wr_reg(3, 8'h0C);
    chk("R9 error set", 32'(cfg_err), 1);
    rd_chk("R9 write took effect", 3, 8'h0C);
    en = '0;
    wr_reg(3, 8'h01);
    chk("R9 error sticky", 32'(cfg_err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_regmap();
    t_level0();
    t_cpu();
    t_highest();
    t_fast();
    t_latency();
    t_random();
    t_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_200_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule